// File: doc/BRIEF.md
# Paged Program Address Sequencer

This block produces the program memory fetch address for a small nibble-wide controller. The address is a 4-bit page in the upper bits and a 6-bit word in the lower bits. Straight-line code advances only the word, so execution stays inside one 64-word page and wraps around within it. To leave the page, software first writes the destination page into a page buffer and then executes a taken jump or call. Only at that point is the buffered page copied into the live page register.

Calls push the address of the next instruction, both its page and its word, onto a small hardware stack whose depth is a parameter (two by default). A return restores both halves, so a subroutine can live on another page. The instruction decoder drives one-cycle strobes together with `step`, which marks a cycle in which an instruction completes. Every port is a plain control or status pin, because no data stream passes through the block.

Top module: `paged_addr_seq`

## Requirements
- R1: Asynchronous active-low reset sets the fetch address to 0, the page buffer to 0 and `stack_ovf` to 0. Because the buffer is 0, a taken jump issued straight after reset goes to page 0.
- R2: On a step with no strobe asserted, the word (`fetch_addr[5:0]`) increments modulo 64 and the page (`fetch_addr[9:6]`) is unchanged.
- R3: While `step` is low, `fetch_addr` and `stack_ovf` hold their values, whatever the strobes are.
- R4: A step with `ld_page` loads `page_imm` into the page buffer and increments the word. The page register keeps its value.
- R5: A step with `jump` and `cond` high loads `target` into the word and the page buffer into the page.
- R6: A `jump` or `call` step with `cond` low acts as a plain increment and does not touch the stack.
- R7: A step with `call` and `cond` high pushes the pair (page, (word+1) mod 64), then loads the word from `target` and the page from the buffer.
- R8: A step with `ret` loads both the page and the word from the top stack entry and removes that entry.
- R9: The stack is last-in first-out over the `STACK_DEPTH` levels.
- R10: A push onto a full stack discards the oldest entry and sets `stack_ovf`. The flag stays set until reset.
- R11: A `ret` on an empty stack sends the address to page 0, word 0.
- R12: When several strobes are present in one step, the priority is `ret`, then taken `call`, then taken `jump`, then `ld_page`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | An instruction completes this cycle |
| ld_page | input | 1 | Load the page buffer from `page_imm` |
| jump | input | 1 | Conditional jump strobe |
| call | input | 1 | Conditional call strobe |
| ret | input | 1 | Return strobe |
| cond | input | 1 | Status flag; a jump or call is taken when it is 1 |
| target | input | 6 | Word operand of a jump or call |
| page_imm | input | 4 | Immediate value for the page buffer |
| fetch_addr | output | 10 | Page (bits 9:6) and word (bits 5:0) of the next fetch |
| stack_ovf | output | 1 | Sticky stack overflow flag |

## Verification
On every cycle the assertions check the hold behaviour, the increment of a plain step, the page staying put on a buffer load, the word loaded by a taken jump or call, the fall-through of an untaken one, and the stickiness of the overflow flag. Some behaviours only the bench's scenarios can show, because they need the stored history: the return address restored across pages, the LIFO order of nested calls, the loss of the oldest entry on overflow, the zero address returned from an empty stack, and the page buffer's contents. A behavioural model with a queue as its stack checks those against the address on every clock.

// File: rtl/addr_seq_pkg.sv
package addr_seq_pkg;
  typedef enum logic [2:0] {
    ACT_HOLD = 3'd0,
    ACT_INC  = 3'd1,
    ACT_LDPG = 3'd2,
    ACT_JUMP = 3'd3,
    ACT_CALL = 3'd4,
    ACT_RET  = 3'd5
  } seq_act_e;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import addr_seq_pkg::*;
(
  input  logic     step,
  input  logic     ld_page,
  input  logic     jump,
  input  logic     call,
  input  logic     ret,
  input  logic     cond,
  output seq_act_e act
);
  always_comb begin
    if (!step)              act = ACT_HOLD;
    else if (ret)           act = ACT_RET;
    else if (call && cond)  act = ACT_CALL;
    else if (jump && cond)  act = ACT_JUMP;
    else if (ld_page)       act = ACT_LDPG;
    else                    act = ACT_INC;
  end
endmodule

// File: rtl/seq_stack.sv
module seq_stack #(
  parameter int WORD_W = 6,
  parameter int PAGE_W = 4,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [WORD_W-1:0] push_word,
  input  logic [PAGE_W-1:0] push_page,
  output logic [WORD_W-1:0] top_word,
  output logic [PAGE_W-1:0] top_page,
  output logic              ovf
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] word_q [DEPTH];
  logic [PAGE_W-1:0] page_q [DEPTH];
  logic [CW-1:0]     count_q;
  logic              full, empty;

  assign full  = (count_q == CW'(DEPTH));
  assign empty = (count_q == '0);

  genvar i;
  generate
    for (i = 0; i < DEPTH; i++) begin : g_lvl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          word_q[i] <= '0;
          page_q[i] <= '0;
        end else if (push) begin
          if (i == 0) begin
            word_q[i] <= push_word;
            page_q[i] <= push_page;
          end else begin
            word_q[i] <= word_q[(i == 0) ? 0 : i - 1];
            page_q[i] <= page_q[(i == 0) ? 0 : i - 1];
          end
        end else if (pop) begin
          if (i == DEPTH - 1) begin
            word_q[i] <= '0;
            page_q[i] <= '0;
          end else begin
            word_q[i] <= word_q[(i == DEPTH - 1) ? i : i + 1];
            page_q[i] <= page_q[(i == DEPTH - 1) ? i : i + 1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      ovf     <= 1'b0;
    end else if (push) begin
      if (full) ovf <= 1'b1;
      else      count_q <= count_q + 1'b1;
    end else if (pop && !empty) begin
      count_q <= count_q - 1'b1;
    end
  end

  assign top_word = empty ? '0 : word_q[0];
  assign top_page = empty ? '0 : page_q[0];
endmodule

// File: rtl/paged_addr_seq.sv
module paged_addr_seq
  import addr_seq_pkg::*;
#(
  parameter int WORD_W      = 6,
  parameter int PAGE_W      = 4,
  parameter int STACK_DEPTH = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step,
  input  logic                     ld_page,
  input  logic                     jump,
  input  logic                     call,
  input  logic                     ret,
  input  logic                     cond,
  input  logic [WORD_W-1:0]        target,
  input  logic [PAGE_W-1:0]        page_imm,
  output logic [PAGE_W+WORD_W-1:0] fetch_addr,
  output logic                     stack_ovf
);
  seq_act_e          act;
  logic [WORD_W-1:0] word_q, word_inc, top_word;
  logic [PAGE_W-1:0] page_q, pbuf_q, top_page;

  assign word_inc = word_q + 1'b1;

  seq_decode u_dec (
    .step(step), .ld_page(ld_page), .jump(jump), .call(call),
    .ret(ret), .cond(cond), .act(act)
  );

  seq_stack #(.WORD_W(WORD_W), .PAGE_W(PAGE_W), .DEPTH(STACK_DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_n),
    .push(act == ACT_CALL), .pop(act == ACT_RET),
    .push_word(word_inc), .push_page(page_q),
    .top_word(top_word), .top_page(top_page), .ovf(stack_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      page_q <= '0;
      pbuf_q <= '0;
    end else begin
      unique case (act)
        ACT_INC:  word_q <= word_inc;
        ACT_LDPG: begin
          word_q <= word_inc;
          pbuf_q <= page_imm;
        end
        ACT_JUMP, ACT_CALL: begin
          word_q <= target;
          page_q <= pbuf_q;
        end
        ACT_RET: begin
          word_q <= top_word;
          page_q <= top_page;
        end
        default: ;
      endcase
    end
  end

  assign fetch_addr = {page_q, word_q};
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int WORD_W = 6,
  parameter int PAGE_W = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     step,
  input logic                     ld_page,
  input logic                     jump,
  input logic                     call,
  input logic                     ret,
  input logic                     cond,
  input logic [WORD_W-1:0]        target,
  input logic [PAGE_W+WORD_W-1:0] fetch_addr,
  input logic                     stack_ovf
);
  logic [WORD_W-1:0] w;
  logic [PAGE_W-1:0] p;
  logic plain, taken, untaken;
  assign w = fetch_addr[WORD_W-1:0];
  assign p = fetch_addr[PAGE_W+WORD_W-1:WORD_W];
  assign plain   = step && !ld_page && !jump && !call && !ret;
  assign taken   = step && !ret && (jump || call) && cond;
  assign untaken = step && !ret && !ld_page && (jump || call) && !cond;

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(fetch_addr) && $stable(stack_ovf));

  p_seq_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    plain |=> (w == WORD_W'($past(w) + 1'b1)) && $stable(p));

  p_ldpage_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ld_page && !jump && !call && !ret) |=> $stable(p));

  p_taken_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> w == $past(target));

  p_untaken_r6: assert property (@(posedge clk) disable iff (!rst_n)
    untaken |=> (w == WORD_W'($past(w) + 1'b1)) && $stable(p));

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stack_ovf |=> stack_ovf);
endmodule

bind paged_addr_seq seq_checker #(.WORD_W(WORD_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .ld_page(ld_page), .jump(jump),
  .call(call), .ret(ret), .cond(cond), .target(target),
  .fetch_addr(fetch_addr), .stack_ovf(stack_ovf)
);

// File: tb/sim_paged_addr_seq.sv
module sim_paged_addr_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step = 0, ld_page = 0, jump = 0, call = 0, ret = 0, cond = 0;
  logic [5:0] target = '0;
  logic [3:0] page_imm = '0;
  logic [9:0] fetch_addr;
  logic stack_ovf;

  int checks = 0, errors = 0;
  int m_word = 0, m_page = 0, m_buf = 0;
  bit m_ovf = 0;
  int stk[$];

  always #5 clk = ~clk;

  paged_addr_seq u0 (
    .clk(clk), .rst_n(rst_n), .step(step), .ld_page(ld_page), .jump(jump),
    .call(call), .ret(ret), .cond(cond), .target(target), .page_imm(page_imm),
    .fetch_addr(fetch_addr), .stack_ovf(stack_ovf)
  );

  task automatic compare(string tag);
    int exp_addr;
    exp_addr = m_page * 64 + m_word;
    checks++;
    if (int'(fetch_addr) != exp_addr || stack_ovf != m_ovf) begin
      errors++;
      $display("FAIL %s: addr=%0d ovf=%0b expected addr=%0d ovf=%0b",
               tag, fetch_addr, stack_ovf, exp_addr, m_ovf);
    end
  endtask

  task automatic model_update();
    int v;
    if (!step) return;
    if (ret) begin
      v = (stk.size() == 0) ? 0 : stk.pop_front();
      m_page = v / 64; m_word = v % 64;
    end else if ((call || jump) && cond) begin
      if (call) begin
        stk.push_front(m_page * 64 + (m_word + 1) % 64);
        if (stk.size() > 2) begin
          void'(stk.pop_back());
          m_ovf = 1;
        end
      end
      m_word = int'(target); m_page = m_buf;
    end else begin
      if (ld_page) m_buf = int'(page_imm);
      m_word = (m_word + 1) % 64;
    end
  endtask

  task automatic cyc(string tag, bit s, bit lp, bit j, bit c, bit r, bit f,
                     int tgt, int im);
    step = s; ld_page = lp; jump = j; call = c; ret = r; cond = f;
    target = 6'(tgt); page_imm = 4'(im);
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    rst_n = 0;
    step = 0; ld_page = 0; jump = 0; call = 0; ret = 0; cond = 0;
    repeat (2) @(negedge clk);
    m_word = 0; m_page = 0; m_buf = 0; m_ovf = 0; stk.delete();
    compare("R1");
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1: page buffer cleared, taken jump lands on page 0
    cyc("R1", 1,0,1,0,0,1, 12, 0);
    // R2: straight-line run, wrapping in page
    for (int i = 0; i < 70; i++) cyc("R2", 1,0,0,0,0,0, 0, 0);
    // R3: no step, strobes ignored
    for (int i = 0; i < 4; i++) cyc("R3", 0,1,1,1,0,1, 40, 9);
    cyc("R3", 0,0,0,0,1,0, 0, 0);
    // R4: buffer load keeps page
    cyc("R4", 1,1,0,0,0,0, 0, 5);
    cyc("R4", 1,0,0,0,0,0, 0, 0);
    // R6: untaken jump and call fall through
    cyc("R6", 1,0,1,0,0,0, 33, 0);
    cyc("R6", 1,0,0,1,0,0, 33, 0);
    // R5: taken jump to page 5 word 10
    cyc("R5", 1,0,1,0,0,1, 10, 0);
    // R11: empty stack pop gives 0 (untaken call pushed nothing)
    cyc("R11", 1,0,0,0,1,0, 0, 0);
    // R7/R9/R8: nested calls across pages
    cyc("R4", 1,1,0,0,0,0, 0, 3);
    cyc("R7", 1,0,0,1,0,1, 20, 0);
    cyc("R4", 1,1,0,0,0,0, 0, 7);
    cyc("R9", 1,0,0,1,0,1, 30, 0);
    cyc("R2", 1,0,0,0,0,0, 0, 0);
    cyc("R8", 1,0,0,0,1,0, 0, 0);
    cyc("R9", 1,0,0,0,1,0, 0, 0);
    cyc("R11", 1,0,0,0,1,0, 0, 0);
    // R7: call from word 63 returns to word 0 of same page
    cyc("R4", 1,1,0,0,0,0, 0, 2);
    cyc("R5", 1,0,1,0,0,1, 63, 0);
    cyc("R4", 1,1,0,0,0,0, 0, 9);
    cyc("R5", 1,0,1,0,0,1, 63, 0);
    cyc("R7", 1,0,0,1,0,1, 5, 0);
    cyc("R8", 1,0,0,0,1,0, 0, 0);
    // R10: three calls overflow the two-level stack
    cyc("R10", 1,0,0,1,0,1, 1, 0);
    cyc("R10", 1,1,0,0,0,0, 0, 4);
    cyc("R10", 1,0,0,1,0,1, 2, 0);
    cyc("R10", 1,0,0,1,0,1, 3, 0);
    cyc("R10", 1,0,0,0,1,0, 0, 0);
    cyc("R10", 1,0,0,0,1,0, 0, 0);
    cyc("R10", 1,0,0,0,1,0, 0, 0);
    // R12: priority among simultaneous strobes
    cyc("R12", 1,1,0,1,0,1, 17, 6);
    cyc("R12", 1,1,1,1,1,1, 44, 1);
    cyc("R12", 1,1,1,1,0,1, 50, 8);
    cyc("R12", 1,1,1,0,0,1, 22, 11);
    cyc("R12", 1,1,1,0,0,0, 22, 12);
    cyc("R5", 1,0,1,0,0,1, 0, 0);
    // R1: reset clears overflow and buffer
    do_reset();
    cyc("R1", 1,0,1,0,0,1, 7, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule